// File: doc/BRIEF.md
# Strobed APB4 Register Bank with Protection Check

This block is a bus completer on an APB4 port. It holds a small bank of 32-bit control words that user logic reads in parallel from a flat output vector. Software writes the words through the bus. Each write can touch any subset of the four byte lanes, selected by the strobe bits. A read returns a whole word.

Every access phase is stretched by a fixed number of wait cycles, set at build time. The block flags an error response in two cases: an offset that maps to no register, and a non-secure access to the one word that is reserved for secure masters. An access that is flagged as an error never alters the bank. Registers sit at word-aligned offsets 4*i, and the register index is taken from address bits [ADDR_W-1:2].

Top module: `apb_regbank`

## Requirements
- R1: While presetn is low, every register is zero, regs_o is zero and pready is low.
- R2: pready is high only when psel and penable are both high. In an access phase, pready stays low for the first WAIT_N cycles and goes high in access cycle WAIT_N+1. With the default WAIT_N=2, an access phase lasts 3 cycles.
- R3: A register changes only at the clock edge that ends an access cycle in which psel, penable, pready and pwrite are all high. A setup phase, or an access cycle with pready low, leaves every register unchanged, however long it is held.
- R4: A write updates bits 8n+7 down to 8n only when pstrb[n] is set. The other lanes keep their old value, and pstrb of zero leaves the word unchanged.
- R5: In the cycle where pready is high, a read of a mapped offset 4*i returns register i on prdata, with pslverr low.
- R6: An offset with paddr[1:0] not zero, or with index paddr[ADDR_W-1:2] of NUM_REGS or more, returns pslverr high. The response carries prdata of zero on a read, and the access modifies no register.
- R7: Register SECURE_IDX (default 3, offset 0x0C) is secure-only. With pprot[1]=1 (non-secure), an access to it returns pslverr high, reads as zero and leaves the register unchanged. With pprot[1]=0, it behaves like any other register.
- R8: pprot[0] (privileged) and pprot[2] (instruction) do not affect the response, the read data or the register contents.
- R9: pslverr is high only in a cycle where pready is high.
- R10: regs_o carries register i on bits [32*i+31 : 32*i] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, rising edge active |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | High in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pprot | input | 3 | Protection attributes; bit 1 = non-secure |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write enables |
| prdata | output | 32 | Read data, valid when pready is high |
| pready | output | 1 | Access-phase completion |
| pslverr | output | 1 | Error response, valid with pready |
| regs_o | output | 32*NUM_REGS | All registers, register i in slice i |

## Verification
The hardest situation to reach is a denied access that coincides with a long access phase: a non-secure write to the secure word, or a write to an unmapped offset, whose wait cycles pass with the strobes set and write data present, yet must still leave the bank untouched when pready finally rises. The stimulus drives exactly these transfers with every strobe set. It also holds a write's setup phase for several cycles and issues writes with partial and empty strobes. A behavioural model follows every cycle and compares pready, pslverr, the read data and the full register vector.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  strb_t;

    // Verdict of the address and protection decoder.
    typedef struct packed {
        logic hit;   // offset maps to a register
        logic deny;  // mapped, but the protection check refuses it
    } verdict_t;
endpackage

// File: rtl/regbank_wait.sv
module regbank_wait #(
    parameter int WAIT_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ready
);
    localparam int CW = (WAIT_N > 0) ? $clog2(WAIT_N + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_N);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wst_t;

    wst_t st_d, st_q;

    assign ready = access && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (access && !ready) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_REGS   = 4,
    parameter int SECURE_IDX = 3
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        nonsec,
    output verdict_t                    verdict,
    output logic [$clog2(NUM_REGS)-1:0] idx
);
    localparam int FW = ADDR_W - 2;
    localparam int IW = $clog2(NUM_REGS);
    localparam logic [FW-1:0] LIMIT  = FW'(NUM_REGS);
    localparam logic [FW-1:0] SECURE = FW'(SECURE_IDX);

    logic [FW-1:0] word_sel;

    assign word_sel = addr[ADDR_W-1:2];
    assign idx      = word_sel[IW-1:0];

    always_comb begin
        verdict.hit  = (addr[1:0] == 2'b00) && (word_sel < LIMIT);
        verdict.deny = verdict.hit && nonsec && (word_sel == SECURE);
    end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [$clog2(NUM_REGS)-1:0] idx,
    input  word_t                       wdata,
    input  strb_t                       wstrb,
    output word_t                       rword,
    output logic [NUM_REGS*WORD_W-1:0]  regs_flat
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] bank;
    } sst_t;

    sst_t  st_d, st_q;
    word_t lane_mask;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{wstrb[b]}};
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
        assign regs_flat[i*WORD_W +: WORD_W] = st_q.bank[i];
    end

    assign rword = st_q.bank[idx];

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bank[idx] = (st_q.bank[idx] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/apb_regbank.sv
module apb_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_REGS   = 4,
    parameter int WAIT_N     = 2,
    parameter int SECURE_IDX = 3
) (
    input  logic                       pclk,
    input  logic                       presetn,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [2:0]                 pprot,
    input  logic [WORD_W-1:0]          pwdata,
    input  logic [LANES-1:0]           pstrb,
    output logic [WORD_W-1:0]          prdata,
    output logic                       pready,
    output logic                       pslverr,
    output logic [NUM_REGS*WORD_W-1:0] regs_o
);
    localparam int IW = $clog2(NUM_REGS);

    logic          access;
    logic          refuse;
    logic          commit;
    logic          unused_prot;
    verdict_t      verdict;
    logic [IW-1:0] idx;
    word_t         rword;

    // Only the security bit takes part in the decision.
    assign unused_prot = pprot[0] ^ pprot[2];

    assign access  = psel && penable;
    assign refuse  = !verdict.hit || verdict.deny;
    assign commit  = pready && pwrite && !refuse;
    assign pslverr = pready && refuse;
    assign prdata  = (psel && !pwrite && !refuse) ? rword : '0;

    regbank_wait #(
        .WAIT_N (WAIT_N)
    ) u_wait (
        .clk    (pclk),
        .rst_n  (presetn),
        .access (access),
        .ready  (pready)
    );

    regbank_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_REGS   (NUM_REGS),
        .SECURE_IDX (SECURE_IDX)
    ) u_decode (
        .addr    (paddr),
        .nonsec  (pprot[1]),
        .verdict (verdict),
        .idx     (idx)
    );

    regbank_store #(
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk       (pclk),
        .rst_n     (presetn),
        .we        (commit),
        .idx       (idx),
        .wdata     (pwdata),
        .wstrb     (pstrb),
        .rword     (rword),
        .regs_flat (regs_o)
    );
endmodule

// File: rtl/apb_regbank_chk.sv
module apb_regbank_chk #(
    parameter int NUM_REGS = 4,
    parameter int WAIT_N   = 2
) (
    input logic                      pclk,
    input logic                      presetn,
    input logic                      psel,
    input logic                      penable,
    input logic                      pwrite,
    input logic [31:0]               prdata,
    input logic                      pready,
    input logic                      pslverr,
    input logic [NUM_REGS*32-1:0]    regs_o
);
    logic [15:0] waited;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            waited <= '0;
        end else if (psel && penable && !pready) begin
            waited <= waited + 1'b1;
        end else begin
            waited <= '0;
        end
    end

    a_r2_ready_in_access: assert property (@(posedge pclk) disable iff (!presetn)
        pready |-> (psel && penable));

    a_r2_wait_count: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable) |-> (pready == (waited == 16'(WAIT_N))));

    a_r9_err_with_ready: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> pready);

    a_r3_no_commit_no_change: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && pready && pwrite) |=> $stable(regs_o));

    a_r6_err_write_no_change: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && pwrite) |=> $stable(regs_o));

    a_r6_err_read_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && !pwrite) |-> (prdata == '0));
endmodule

bind apb_regbank apb_regbank_chk #(
    .NUM_REGS (NUM_REGS),
    .WAIT_N   (WAIT_N)
) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .regs_o  (regs_o)
);

// File: tb/apb_regbank_bench.sv
module apb_regbank_bench;
    localparam int PERIOD     = 10;
    localparam int NUM_REGS   = 4;
    localparam int WAIT_N     = 2;
    localparam int SECURE_IDX = 3;

    logic        pclk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [2:0]  pprot;
    logic [31:0] pwdata;
    logic [3:0]  pstrb;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [127:0] regs_o;

    int    vectors = 0;
    int    fails   = 0;
    string tag     = "R1";

    logic [31:0] model [NUM_REGS];
    int          wcnt = 0;
    logic        last_ready, last_err;
    logic [31:0] last_rdata;

    always #(PERIOD/2) pclk = ~pclk;

    apb_regbank u_apb_regbank (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pprot   (pprot),
        .pwdata  (pwdata),
        .pstrb   (pstrb),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .regs_o  (regs_o)
    );

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model, then advance one clock.
    task automatic tick();
        bit acc, rdy_e, hit, err;
        int idx;
        logic [127:0] flat;
        #(PERIOD/4);
        acc   = psel && penable;
        rdy_e = acc && (wcnt == WAIT_N);
        idx   = int'(paddr) / 4;
        hit   = (paddr[1:0] == 2'b00) && (idx < NUM_REGS);
        err   = !hit || (idx == SECURE_IDX && pprot[1]);
        for (int i = 0; i < NUM_REGS; i++) flat[32*i +: 32] = model[i];
        check(pready === rdy_e, "pready (R2)", 128'(pready), 128'(rdy_e));
        check(pslverr === (rdy_e && err), "pslverr (R9)", 128'(pslverr), 128'(rdy_e && err));
        check(regs_o === flat, "regs_o (R10)", regs_o, flat);
        if (rdy_e && !pwrite) begin
            check(prdata === (err ? 32'h0 : model[idx]), "prdata",
                  128'(prdata), 128'(err ? 32'h0 : model[idx]));
        end
        last_ready = pready;
        last_err   = pslverr;
        last_rdata = prdata;
        @(posedge pclk);
        if (acc && !rdy_e) wcnt++;
        else wcnt = 0;
        if (rdy_e && pwrite && !err) begin
            for (int b = 0; b < 4; b++) begin
                if (pstrb[b]) model[idx][8*b +: 8] = pwdata[8*b +: 8];
            end
        end
        @(negedge pclk);
    endtask

    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        input logic [3:0] st, input logic [2:0] pr,
                        output logic [31:0] rd, output bit er, output int ncyc);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
        pwdata = wd; pstrb = st; pprot = pr;
        tick();
        penable = 1'b1;
        ncyc = 0;
        do begin
            tick();
            ncyc++;
        end while (!last_ready && ncyc < 50);
        rd = last_rdata;
        er = last_err;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = 4'h0;
        tick();
    endtask

    initial begin
        logic [31:0] rd;
        bit er;
        int n;
        presetn = 1'b0;
        psel = 0; penable = 0; pwrite = 0; paddr = 0; pprot = 0; pwdata = 0; pstrb = 0;
        for (int i = 0; i < NUM_REGS; i++) model[i] = 32'h0;
        repeat (3) @(negedge pclk);
        tag = "R1";
        check(regs_o === 128'h0, "regs_o in reset", regs_o, 128'h0);
        check(pready === 1'b0, "pready in reset", 128'(pready), 128'h0);
        presetn = 1'b1;
        @(negedge pclk);

        tag = "R5";
        xfer(1, 8'h00, 32'h01234567, 4'hF, 3'b000, rd, er, n);
        tag = "R2";
        check(n == WAIT_N + 1, "access length", 128'(n), 128'(WAIT_N + 1));
        tag = "R5";
        xfer(1, 8'h04, 32'h89ABCDEF, 4'hF, 3'b000, rd, er, n);
        xfer(1, 8'h08, 32'hDEADBEEF, 4'hF, 3'b000, rd, er, n);
        xfer(1, 8'h0C, 32'h0F1E2D3C, 4'hF, 3'b000, rd, er, n);
        xfer(0, 8'h08, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(rd === 32'hDEADBEEF, "read reg2", 128'(rd), 128'hDEADBEEF);
        check(er === 1'b0, "read reg2 err", 128'(er), 128'h0);
        tag = "R2";
        check(n == WAIT_N + 1, "read access length", 128'(n), 128'(WAIT_N + 1));

        tag = "R4";
        xfer(1, 8'h04, 32'hAABBCCDD, 4'b0101, 3'b000, rd, er, n);
        xfer(0, 8'h04, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(rd === 32'h89BBCDDD, "lanes 0,2", 128'(rd), 128'h89BBCDDD);
        xfer(1, 8'h04, 32'h77000000, 4'b1000, 3'b000, rd, er, n);
        xfer(1, 8'h04, 32'hFFFFFFFF, 4'b0000, 3'b000, rd, er, n);
        xfer(0, 8'h04, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(rd === 32'h77BBCDDD, "lane 3 then empty strobe", 128'(rd), 128'h77BBCDDD);

        tag = "R3";
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00;
        pwdata = 32'hCAFEF00D; pstrb = 4'hF; pprot = 3'b000;
        repeat (4) tick();
        psel = 1'b0; pwrite = 1'b0;
        tick();
        xfer(0, 8'h00, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(rd === 32'h01234567, "held setup no write", 128'(rd), 128'h01234567);

        tag = "R6";
        xfer(1, 8'h10, 32'hFFFFFFFF, 4'hF, 3'b000, rd, er, n);
        check(er === 1'b1, "unmapped write err", 128'(er), 128'h1);
        xfer(1, 8'h06, 32'hFFFFFFFF, 4'hF, 3'b000, rd, er, n);
        check(er === 1'b1, "misaligned write err", 128'(er), 128'h1);
        xfer(0, 8'h10, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(er === 1'b1 && rd === 32'h0, "unmapped read", 128'({er, rd}), 128'({1'b1, 32'h0}));

        tag = "R7";
        xfer(1, 8'h0C, 32'h00000000, 4'hF, 3'b010, rd, er, n);
        check(er === 1'b1, "nonsecure write err", 128'(er), 128'h1);
        xfer(0, 8'h0C, 32'h0, 4'h0, 3'b010, rd, er, n);
        check(er === 1'b1 && rd === 32'h0, "nonsecure read", 128'({er, rd}), 128'({1'b1, 32'h0}));
        xfer(0, 8'h0C, 32'h0, 4'h0, 3'b000, rd, er, n);
        check(rd === 32'h0F1E2D3C && er === 1'b0, "secure read intact",
              128'({er, rd}), 128'({1'b0, 32'h0F1E2D3C}));
        xfer(0, 8'h08, 32'h0, 4'h0, 3'b010, rd, er, n);
        check(rd === 32'hDEADBEEF && er === 1'b0, "nonsecure ordinary reg",
              128'({er, rd}), 128'({1'b0, 32'hDEADBEEF}));

        tag = "R8";
        xfer(1, 8'h0C, 32'h55AA55AA, 4'hF, 3'b101, rd, er, n);
        check(er === 1'b0, "priv/instr write ok", 128'(er), 128'h0);
        xfer(0, 8'h0C, 32'h0, 4'h0, 3'b100, rd, er, n);
        check(rd === 32'h55AA55AA && er === 1'b0, "instr read",
              128'({er, rd}), 128'({1'b0, 32'h55AA55AA}));

        tag = "R10";
        check(regs_o[31:0] === 32'h01234567, "slice 0", 128'(regs_o[31:0]), 128'h01234567);
        check(regs_o[63:32] === 32'h77BBCDDD, "slice 1", 128'(regs_o[63:32]), 128'h77BBCDDD);
        check(regs_o[127:96] === 32'h55AA55AA, "slice 3", 128'(regs_o[127:96]), 128'h55AA55AA);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule